// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings close to the load/store path. A lookup presents a 20-bit virtual page number. It is compared against every stored tag at once, and the registered answer appears on the next clock edge. A hit returns the physical page number together with its read, write, execute and dirty flags. A miss tells the caller that a page-table walk is needed.

After a walk the caller writes the resulting mapping back with a fill, then retries the access. A fill whose tag is already present rewrites that slot. Otherwise the fill takes the lowest-numbered empty slot, and only when every slot is valid does it evict the least recently used one. A whole-buffer flush is used when the page-table base changes. A targeted invalidate removes one mapping after its table entry has been edited.

If a lookup hit and a fill happen in the same cycle, only the filled slot is refreshed in the recency order.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, and any lookup misses.
- R2: A lookup of a stored page sets `rsp_valid` and `rsp_hit` on the next edge, clears `rsp_miss`, and returns the stored `rsp_ppn` and `rsp_perm`. The bits of `rsp_perm` are: bit 0 read, bit 1 write, bit 2 execute, bit 3 dirty.
- R3: A lookup of an absent page sets `rsp_valid` and `rsp_miss` on the next edge, with `rsp_hit` low. In a cycle with no lookup, all three signals are low on the next edge.
- R4: A fill can be looked up with a hit from the cycle after it is accepted, and its page number and flags are returned unchanged.
- R5: When every slot is valid, a fill of a new page evicts the slot that was least recently filled or hit.
- R6: A fill whose page is already stored rewrites that slot. No second copy is created, and no other mapping is displaced.
- R7: While any slot is empty, a fill of a new page uses an empty slot and evicts no valid mapping.
- R8: After a flush every slot is empty.
- R9: A fill presented in the same cycle as a flush is discarded.
- R10: An invalidate removes only the mapping with the given page. An invalidate of an absent page changes nothing.
- R11: Invalidates do not alter the recency order of the surviving mappings.
- R12: A fill and an invalidate of the same page in the same cycle leave that page absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Mapping found |
| rsp_miss | output | 1 | Mapping absent; a walk is needed |
| rsp_ppn | output | 20 | Physical page number on a hit |
| rsp_perm | output | 4 | Flags on a hit: {dirty, execute, write, read} |
| fill_valid | input | 1 | Write a walked mapping |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_perm | input | 4 | Flags of the fill, same layout as rsp_perm |
| flush | input | 1 | Invalidate every slot |
| inv_valid | input | 1 | Invalidate one mapping |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
The bench targets the replacement order. A design that refreshed recency on the wrong event, or evicted a valid slot while an empty one remained, would later miss on a page that should still be stored. Refills of a page that is already present are checked for duplicates, since a duplicate would silently push out an unrelated mapping. Collisions are also exercised: a fill in the same cycle as a flush or as an invalidate of its own page must leave no trace. A long pseudo-random sweep over eight pages on a four-slot configuration then compares every lookup against an independent timestamp model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;

    typedef struct packed {
        logic dirty;
        logic exec;
        logic write;
        logic read;
    } perm_t;

    typedef struct packed {
        vpn_t  tag;
        ppn_t  ppn;
        perm_t perm;
    } slot_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       valid_vec,
    input  vpn_t [DEPTH-1:0]       tag_vec,
    input  vpn_t                   key,
    output logic                   any,
    output logic [IW-1:0]          idx
);
    logic [DEPTH-1:0] eq_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq_vec[g] = valid_vec[g] && (tag_vec[g] == key);
    end

    assign any = |eq_vec;

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq_vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic [DEPTH-1:0]       kill_vec,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  slot_t                  wr_slot,
    output logic [DEPTH-1:0]       valid_vec,
    output vpn_t [DEPTH-1:0]       tag_vec,
    output slot_t [DEPTH-1:0]      slots
);
    logic  [DEPTH-1:0]  valid_q;
    slot_t [DEPTH-1:0]  slots_q;
    logic  [DEPTH-1:0]  set_vec;

    assign set_vec = wr_en ? (DEPTH'(1) << wr_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else begin
            valid_q <= (valid_q & ~kill_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else if (wr_en) begin
            slots_q[wr_idx] <= wr_slot;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
        assign tag_vec[g] = slots_q[g].tag;
    end

    assign valid_vec = valid_q;
    assign slots     = slots_q;
endmodule

// File: rtl/xlat_recency.sv
module xlat_recency #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       touch_en,
    input  logic [IW-1:0]              touch_idx,
    input  logic [DEPTH-1:0]           valid_vec,
    output logic [IW-1:0]              victim_idx,
    output logic [DEPTH-1:0][IW-1:0]   age_vec
);
    localparam logic [IW-1:0] OLDEST = IW'(DEPTH - 1);

    logic [DEPTH-1:0][IW-1:0] age_q;
    logic [IW-1:0]            touch_age;
    logic                     free_any;
    logic [IW-1:0]            free_idx;
    logic [IW-1:0]            old_idx;

    assign touch_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) age_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IW'(i) == touch_idx)        age_q[i] <= '0;
                else if (age_q[i] < touch_age)  age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
            if (age_q[i] == OLDEST) old_idx = IW'(i);
        end
        victim_idx = free_any ? free_idx : old_idx;
    end

    assign age_vec = age_q;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [3:0]       rsp_perm,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [3:0]       fill_perm,
    input  logic             flush,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn
);
    localparam int IW = $clog2(DEPTH);

    logic  [DEPTH-1:0]          valid_vec;
    vpn_t  [DEPTH-1:0]          tag_vec;
    slot_t [DEPTH-1:0]          slots;
    logic  [DEPTH-1:0][IW-1:0]  age_vec;

    logic            lk_any,   fill_any,   inv_any;
    logic [IW-1:0]   lk_idx,   fill_hidx,  inv_idx;
    logic [IW-1:0]   victim_idx, fill_idx, touch_idx;
    logic            fill_do, touch_en;
    logic [DEPTH-1:0] kill_vec;
    slot_t           fill_slot;

    xlat_match #(.DEPTH(DEPTH), .IW(IW)) u_lk_match (
        .valid_vec(valid_vec), .tag_vec(tag_vec), .key(lk_vpn),
        .any(lk_any), .idx(lk_idx)
    );

    xlat_match #(.DEPTH(DEPTH), .IW(IW)) u_fill_match (
        .valid_vec(valid_vec), .tag_vec(tag_vec), .key(fill_vpn),
        .any(fill_any), .idx(fill_hidx)
    );

    xlat_match #(.DEPTH(DEPTH), .IW(IW)) u_inv_match (
        .valid_vec(valid_vec), .tag_vec(tag_vec), .key(inv_vpn),
        .any(inv_any), .idx(inv_idx)
    );

    // A flush, or an invalidate of the same page, discards the fill.
    assign fill_do   = fill_valid && !flush && !(inv_valid && (inv_vpn == fill_vpn));
    assign fill_idx  = fill_any ? fill_hidx : victim_idx;
    assign kill_vec  = (inv_valid && inv_any) ? (DEPTH'(1) << inv_idx) : '0;
    assign fill_slot = '{tag: fill_vpn, ppn: fill_ppn, perm: perm_t'(fill_perm)};

    // A fill outranks a lookup hit for the single recency update per cycle.
    assign touch_en  = fill_do || (lk_valid && lk_any);
    assign touch_idx = fill_do ? fill_idx : lk_idx;

    xlat_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .kill_vec(kill_vec),
        .wr_en(fill_do), .wr_idx(fill_idx), .wr_slot(fill_slot),
        .valid_vec(valid_vec), .tag_vec(tag_vec), .slots(slots)
    );

    xlat_recency #(.DEPTH(DEPTH), .IW(IW)) u_recency (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_vec(valid_vec), .victim_idx(victim_idx), .age_vec(age_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any;
            rsp_miss  <= lk_valid && !lk_any;
            rsp_ppn   <= slots[lk_idx].ppn;
            rsp_perm  <= slots[lk_idx].perm;
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      lk_valid,
    input logic                      rsp_valid,
    input logic                      rsp_hit,
    input logic                      rsp_miss,
    input logic                      flush,
    input logic                      inv_valid,
    input logic [VPN_W-1:0]          inv_vpn,
    input logic [DEPTH-1:0]          valid_vec,
    input vpn_t [DEPTH-1:0]          tag_vec,
    input logic [DEPTH-1:0][IW-1:0]  age_vec
);
    vpn_t             prev_inv_vpn;
    logic             prev_present;
    logic             dup_seen;
    logic [DEPTH-1:0] oldest_vec;

    always_ff @(posedge clk) prev_inv_vpn <= inv_vpn;

    always_comb begin
        prev_present = 1'b0;
        dup_seen     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid_vec[i] && tag_vec[i] == prev_inv_vpn) prev_present = 1'b1;
            oldest_vec[i] = (age_vec[i] == IW'(DEPTH - 1));
            for (int j = i + 1; j < DEPTH; j++) begin
                if (valid_vec[i] && valid_vec[j] && tag_vec[i] == tag_vec[j]) dup_seen = 1'b1;
            end
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_vec == '0 && !rsp_valid));

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid));

    // R3
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    // R5
    single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);

    // R6
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst)
        !dup_seen);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R10
    inv_gone_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> !prev_present);
endmodule

bind xlat_cache xlat_cache_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .valid_vec(valid_vec), .tag_vec(tag_vec), .age_vec(age_vec)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [19:0] rsp_ppn;
    logic [3:0]  rsp_perm;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_perm = '0;
    logic        flush = 1'b0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    xlat_cache #(.DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
    );

    // Independent model: timestamps instead of an age ordering.
    logic        m_v   [D];
    logic [19:0] m_tag [D];
    logic [19:0] m_ppn [D];
    logic [3:0]  m_perm[D];
    int unsigned m_ts  [D];
    int unsigned now_t = 0;

    function automatic int m_find(input logic [19:0] vpn);
        for (int i = 0; i < D; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic logic [19:0] ppn_of(input logic [19:0] vpn, input int gen);
        return 20'(vpn * 7 + 20'h3000 + gen * 131);
    endfunction

    function automatic logic [3:0] perm_of(input logic [19:0] vpn, input int gen);
        return 4'(vpn[3:0] ^ 4'(gen) ^ 4'h5);
    endfunction

    task automatic m_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] perm);
        int k;
        k = m_find(vpn);
        if (k < 0) for (int i = 0; i < D; i++) if (!m_v[i] && k < 0) k = i;
        if (k < 0) begin
            k = 0;
            for (int i = 1; i < D; i++) if (m_ts[i] < m_ts[k]) k = i;
        end
        now_t++;
        m_v[k] = 1'b1; m_tag[k] = vpn; m_ppn[k] = ppn; m_perm[k] = perm; m_ts[k] = now_t;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic lv, input logic [19:0] lvpn,
                         input logic fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                         input logic [3:0] fperm, input logic fl,
                         input logic iv, input logic [19:0] ivpn);
        @(negedge clk);
        lk_valid = lv; lk_vpn = lvpn;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm;
        flush = fl; inv_valid = iv; inv_vpn = ivpn;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0; inv_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [19:0] vpn, input string req);
        int k;
        logic [63:0] exp;
        k = m_find(vpn);
        pulse(1'b1, vpn, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0);
        if (k >= 0) exp = {37'h0, 1'b1, 1'b1, 1'b0, m_perm[k], m_ppn[k]};
        else        exp = {37'h0, 1'b1, 1'b0, 1'b1, 24'h0};
        chk(req, {37'h0, rsp_valid, rsp_hit, rsp_miss, rsp_hit ? {rsp_perm, rsp_ppn} : 24'h0}, exp);
        if (k >= 0) begin now_t++; m_ts[k] = now_t; end
    endtask

    task automatic do_fill(input logic [19:0] vpn, input int gen);
        pulse(1'b0, '0, 1'b1, vpn, ppn_of(vpn, gen), perm_of(vpn, gen), 1'b0, 1'b0, '0);
        m_fill(vpn, ppn_of(vpn, gen), perm_of(vpn, gen));
    endtask

    task automatic do_inv(input logic [19:0] vpn);
        int k;
        pulse(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b1, vpn);
        k = m_find(vpn);
        if (k >= 0) m_v[k] = 1'b0;
    endtask

    task automatic do_flush();
        pulse(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, 1'b0, '0);
        for (int i = 0; i < D; i++) m_v[i] = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [19:0] PA = 20'h12345, PB = 20'h00001, PC = 20'hFFFFF,
                            PD = 20'h80000, PE = 20'h0ABCD, PF = 20'h55555,
                            PG = 20'h2AAAA, PX = 20'h70707;

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < D; i++) begin m_v[i] = 1'b0; m_ts[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset, then lookups miss
        chk("R1 reset rsp", {61'h0, rsp_valid, rsp_hit, rsp_miss}, 64'h0);
        do_lookup(PA, "R1 empty lookup");
        do_lookup(20'h0, "R1 empty lookup zero");
        // R3: idle cycle yields no response
        @(negedge clk);
        chk("R3 idle rsp", {61'h0, rsp_valid, rsp_hit, rsp_miss}, 64'h0);

        // R4 / R2: fill then hit with exact fields
        do_fill(PA, 0);
        do_lookup(PA, "R2 R4 hit after fill");
        do_lookup(PX, "R3 miss absent");
        do_fill(PB, 0); do_fill(PC, 0); do_fill(PD, 0);
        do_lookup(PB, "R2 hit B");
        do_lookup(PC, "R2 hit C");
        do_lookup(PD, "R2 hit D");

        // R6: refill of a stored page rewrites in place
        do_fill(PA, 1);
        do_lookup(PA, "R6 rewritten fields");
        do_lookup(PB, "R6 B kept");
        do_lookup(PC, "R6 C kept");
        do_lookup(PD, "R6 D kept");

        // R5: full, A is now least recent
        do_fill(PE, 0);
        do_lookup(PA, "R5 oldest evicted");
        do_lookup(PB, "R5 B kept");
        do_lookup(PE, "R5 E present");

        // R10: targeted invalidate, and of an absent page
        do_inv(PX);
        do_lookup(PC, "R10 absent inv no effect");
        do_inv(PD);
        do_lookup(PD, "R10 D removed");
        do_lookup(PC, "R10 C kept");

        // R7: empty slot taken before any eviction
        do_fill(PF, 0);
        do_lookup(PB, "R7 B kept");
        do_lookup(PC, "R7 C kept");
        do_lookup(PE, "R7 E kept");
        do_lookup(PF, "R7 F present");

        // R11: invalidate leaves recency alone
        do_inv(PC);
        do_fill(PC, 2);
        do_inv(PX);
        do_fill(PG, 0);
        do_lookup(PB, "R11 recency after inv");
        do_lookup(PE, "R11 recency E");
        do_lookup(PF, "R11 recency F");
        do_lookup(PC, "R11 recency C");
        do_lookup(PG, "R11 recency G");

        // R8: flush empties everything
        do_flush();
        do_lookup(PC, "R8 after flush C");
        do_lookup(PG, "R8 after flush G");

        // R9: fill in flush cycle is discarded
        do_fill(PB, 3);
        pulse(1'b0, '0, 1'b1, PA, ppn_of(PA, 4), perm_of(PA, 4), 1'b1, 1'b0, '0);
        for (int i = 0; i < D; i++) m_v[i] = 1'b0;
        do_lookup(PA, "R9 fill dropped");
        do_lookup(PB, "R9 flushed");

        // R12: fill and invalidate of same page
        pulse(1'b0, '0, 1'b1, PX, ppn_of(PX, 0), perm_of(PX, 0), 1'b0, 1'b1, PX);
        do_lookup(PX, "R12 same page fill dropped");

        // R5 sweep: pseudo-random mix over eight pages
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [19:0] v;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = 20'h40000 + 20'(lfsr[2:0]);
            case (lfsr[7:4])
                4'd8, 4'd9, 4'd10, 4'd11, 4'd12: do_fill(v, n);
                4'd13, 4'd14: do_inv(v);
                4'd15: if (lfsr[8]) do_flush(); else do_lookup(v, "R5 sweep");
                default: do_lookup(v, "R5 sweep");
            endcase
        end
        finish_run();
    end
endmodule